// File: doc/BRIEF.md
# Compressed Quadrant-Two Instruction Expander

This combinational block turns a 16-bit compressed instruction from the quadrant whose two low bits are `10` into the equivalent 32-bit base instruction. It handles the stack-relative word and doubleword loads, the register jump and jump-and-link, the breakpoint, the register move and add, and the immediate left shift. The parameter `BASE_W` (32 or 64) selects the base integer width.

The block also classifies every code point that is not a plain legal instruction. A code point is either expanded, expanded and marked as a hint, marked as reserved or illegal, marked as reserved for custom extensions, or decoded as the other instruction that shares its encoding. At most one of the three flags is raised for any input. When the illegal flag or the custom flag is raised, the output word is all zero. A fetch stage places the expander between the aligner and the normal 32-bit decoder.

Top module: `cq2_expander`

## Requirements
- R1: funct3 `010` (bits 15:13) is the word stack load. It expands to `lw rd, off(x2)`, where rd = bits 11:7, off[5] = bit 12, off[4:2] = bits 6:4, off[7:6] = bits 3:2, and all other offset bits are zero.
- R2: A word stack load with rd = x0 is reserved. It raises the illegal flag.
- R3: funct3 `011` is the doubleword stack load, which exists only when BASE_W = 64. It expands to `ld rd, off(x2)` with off[5] = bit 12, off[4:3] = bits 6:5, off[8:6] = bits 4:2. When rd = x0, or when BASE_W = 32, it is illegal.
- R4: funct3 `100` with bit 12 = 0 and bits 6:2 = 0 is the register jump `jalr x0, 0(rs1)`, with rs1 = bits 11:7. When rs1 = x0 it is illegal.
- R5: funct3 `100` with bit 12 = 1 and bits 6:2 = 0 is `jalr x1, 0(rs1)`. When rs1 is also x0 it is the breakpoint, `0x00100073`.
- R6: funct3 `100` with bit 12 = 0 and rs2 (bits 6:2) nonzero is the move `add rd, x0, rs2`. When rd = x0 the expansion is kept and the hint flag is raised.
- R7: funct3 `100` with bit 12 = 1 and rs2 nonzero is `add rd, rd, rs2`. When rd = x0 the expansion is kept and the hint flag is raised.
- R8: funct3 `000` is `slli rd, rd, sh`, with sh[5] = bit 12 and sh[4:0] = bits 6:2. When sh = 0 or rd = x0 the expansion is kept and the hint flag is raised.
- R9: When BASE_W = 32, a left shift with sh[5] = 1 raises only the custom flag and outputs zero, whatever rd is. When BASE_W = 64 the same code point expands to a 6-bit shift.
- R10: funct3 values `001`, `101`, `110` and `111`, and any input whose bits 1:0 are not `10`, raise the illegal flag.
- R11: At most one flag is raised. When the illegal or custom flag is raised, the output is all zero. Any nonzero output has bits 1:0 = `11`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Compressed instruction |
| instr_o | output | 32 | Expanded base instruction, zero when illegal or custom |
| illegal_o | output | 1 | Reserved or illegal code point |
| hint_o | output | 1 | Hint code point, expansion valid |
| custom_o | output | 1 | Code point reserved for custom extensions |

## Verification
Two rules can apply to the same left-shift code point on the 32-bit base. These are the custom reservation for sh[5] = 1 and the hint rule for rd = x0. The bench drives sh = 33 with rd = x0 and with rd nonzero. Only the custom flag may rise, and the output must be zero; the 64-bit instance must expand the same inputs. In the register group, the alias rules (rs2 = 0 selects jump or breakpoint) overlap the hint rule (rd = x0). These are judged by driving rd = x0 together with rs2 = 0 and with rs2 nonzero.

// File: rtl/cq2_pkg.sv
package cq2_pkg;
  typedef struct packed {
    logic [31:0] word;
    logic        ill;
    logic        hint;
    logic        cust;
  } cq2_res_t;

  localparam logic [6:0] OP_LOAD  = 7'h03;
  localparam logic [6:0] OP_IMM   = 7'h13;
  localparam logic [6:0] OP_REG   = 7'h33;
  localparam logic [6:0] OP_JALR  = 7'h67;
  localparam logic [31:0] WORD_BRK = 32'h0010_0073;

  localparam cq2_res_t RES_ILL  = '{word: 32'h0, ill: 1'b1, hint: 1'b0, cust: 1'b0};
  localparam cq2_res_t RES_CUST = '{word: 32'h0, ill: 1'b0, hint: 1'b0, cust: 1'b1};

  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs2, input logic [4:0] rs1,
                                        input logic [4:0] rd);
    return {7'b0, rs2, rs1, 3'b000, rd, OP_REG};
  endfunction
endpackage

// File: rtl/cq2_spload.sv
module cq2_spload
  import cq2_pkg::*;
#(
  parameter int BASE_W = 32
) (
  input  logic [12:2] fld,
  output cq2_res_t    word_res,
  output cq2_res_t    dword_res
);
  localparam logic [4:0] REG_SP = 5'd2;

  logic [4:0]  rd;
  logic [11:0] off_w;
  logic [11:0] off_d;

  assign rd    = fld[11:7];
  assign off_w = {4'b0, fld[3:2], fld[12], fld[6:4], 2'b00};
  assign off_d = {3'b0, fld[4:2], fld[12], fld[6:5], 3'b000};

  always_comb begin
    if (rd == 5'd0) word_res = RES_ILL;
    else            word_res = '{word: enc_i(off_w, REG_SP, 3'b010, rd, OP_LOAD),
                                 ill: 1'b0, hint: 1'b0, cust: 1'b0};
  end

  generate
    if (BASE_W == 64) begin : g_dword
      always_comb begin
        if (rd == 5'd0) dword_res = RES_ILL;
        else            dword_res = '{word: enc_i(off_d, REG_SP, 3'b011, rd, OP_LOAD),
                                      ill: 1'b0, hint: 1'b0, cust: 1'b0};
      end
    end else begin : g_no_dword
      assign dword_res = RES_ILL;
    end
  endgenerate
endmodule

// File: rtl/cq2_regop.sv
module cq2_regop
  import cq2_pkg::*;
(
  input  logic [12:2] fld,
  output cq2_res_t    res
);
  logic       link;
  logic [4:0] rd;
  logic [4:0] rs2;

  assign link = fld[12];
  assign rd   = fld[11:7];
  assign rs2  = fld[6:2];

  always_comb begin
    res = RES_ILL;
    if (rs2 == 5'd0) begin
      if (!link) begin
        if (rd != 5'd0)
          res = '{word: enc_i(12'h0, rd, 3'b000, 5'd0, OP_JALR), ill: 1'b0, hint: 1'b0, cust: 1'b0};
      end else if (rd == 5'd0) begin
        res = '{word: WORD_BRK, ill: 1'b0, hint: 1'b0, cust: 1'b0};
      end else begin
        res = '{word: enc_i(12'h0, rd, 3'b000, 5'd1, OP_JALR), ill: 1'b0, hint: 1'b0, cust: 1'b0};
      end
    end else begin
      res = '{word: enc_r(rs2, link ? rd : 5'd0, rd), ill: 1'b0,
              hint: (rd == 5'd0), cust: 1'b0};
    end
  end
endmodule

// File: rtl/cq2_shift.sv
module cq2_shift
  import cq2_pkg::*;
#(
  parameter int BASE_W = 32
) (
  input  logic [12:2] fld,
  output cq2_res_t    res
);
  localparam bit NARROW = (BASE_W == 32);

  logic [5:0] sh;
  logic [4:0] rd;

  assign sh = {fld[12], fld[6:2]};
  assign rd = fld[11:7];

  always_comb begin
    if (NARROW && sh[5]) res = RES_CUST;
    else res = '{word: enc_i({6'b0, sh}, rd, 3'b001, rd, OP_IMM), ill: 1'b0,
                 hint: (sh == 6'd0) || (rd == 5'd0), cust: 1'b0};
  end
endmodule

// File: rtl/cq2_expander.sv
module cq2_expander
  import cq2_pkg::*;
#(
  parameter int BASE_W = 32
) (
  input  logic [15:0] instr_i,
  output logic [31:0] instr_o,
  output logic        illegal_o,
  output logic        hint_o,
  output logic        custom_o
);
  cq2_res_t lw_res, ld_res, reg_res, sh_res, sel;

  cq2_spload #(.BASE_W(BASE_W)) u_spload (
    .fld(instr_i[12:2]), .word_res(lw_res), .dword_res(ld_res));
  cq2_regop u_regop (.fld(instr_i[12:2]), .res(reg_res));
  cq2_shift #(.BASE_W(BASE_W)) u_shift (.fld(instr_i[12:2]), .res(sh_res));

  always_comb begin
    unique case (instr_i[15:13])
      3'b000:  sel = sh_res;
      3'b010:  sel = lw_res;
      3'b011:  sel = ld_res;
      3'b100:  sel = reg_res;
      default: sel = RES_ILL;
    endcase
    if (instr_i[1:0] != 2'b10) sel = RES_ILL;
  end

  assign instr_o   = sel.word;
  assign illegal_o = sel.ill;
  assign hint_o    = sel.hint;
  assign custom_o  = sel.cust;
endmodule

// File: rtl/cq2_expander_chk.sv
module cq2_expander_chk #(
  parameter int BASE_W = 32
) (
  input logic [2:0]  f3,
  input logic [1:0]  quad,
  input logic [31:0] instr_o,
  input logic        illegal_o,
  input logic        hint_o,
  input logic        custom_o
);
  always_comb begin
    assert_flags_onehot_R11: assert ($onehot0({illegal_o, hint_o, custom_o}))
      else $error("flags not one-hot");
    assert_zero_on_reject_R11: assert (!(illegal_o || custom_o) || instr_o == 32'h0)
      else $error("rejected code point produced a word");
    assert_word_shape_R11: assert (instr_o == 32'h0 || instr_o[1:0] == 2'b11)
      else $error("expanded word not 32-bit form");
    assert_hint_shape_R8: assert (!hint_o || instr_o[11:7] == 5'd0 || instr_o[25:20] == 6'd0)
      else $error("hint without x0 destination or zero shift");
    assert_quadrant_R10: assert (quad == 2'b10 || illegal_o)
      else $error("foreign quadrant accepted");
    assert_unused_f3_R10: assert (!(f3 inside {3'b001, 3'b101, 3'b110, 3'b111}) || illegal_o)
      else $error("unused funct3 accepted");
    assert_no_dword_R3: assert (BASE_W != 32 || f3 != 3'b011 || illegal_o)
      else $error("doubleword load on narrow base");
    assert_custom_base_R9: assert (BASE_W == 32 || !custom_o)
      else $error("custom flag on wide base");
  end
endmodule

bind cq2_expander cq2_expander_chk #(.BASE_W(BASE_W)) u_chk (
  .f3(instr_i[15:13]), .quad(instr_i[1:0]), .instr_o(instr_o),
  .illegal_o(illegal_o), .hint_o(hint_o), .custom_o(custom_o));

// File: tb/cq2_expander_bench.sv
module cq2_expander_bench;
  logic clk;
  logic rst_n;
  logic [15:0] cin;
  logic [31:0] w32, w64;
  logic i32, h32, c32, i64, h64, c64;
  int errors = 0;
  int checks = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  cq2_expander #(.BASE_W(32)) u_cq2_expander (
    .instr_i(cin), .instr_o(w32), .illegal_o(i32), .hint_o(h32), .custom_o(c32));
  cq2_expander #(.BASE_W(64)) u_cq2_expander64 (
    .instr_i(cin), .instr_o(w64), .illegal_o(i64), .hint_o(h64), .custom_o(c64));

  function automatic logic [31:0] ei(input logic [11:0] imm, input logic [4:0] rs1,
                                     input logic [2:0] f3, input logic [4:0] rd,
                                     input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] er(input logic [4:0] rs2, input logic [4:0] rs1,
                                     input logic [4:0] rd);
    return {7'b0, rs2, rs1, 3'b000, rd, 7'h33};
  endfunction

  task automatic drive(input logic [15:0] c);
    @(negedge clk);
    cin = c;
    #1;
  endtask

  task automatic chk(input string tag, input bit wide, input logic [31:0] ew,
                     input logic eil, input logic eh, input logic ec);
    logic [34:0] act, exp;
    act = wide ? {w64, i64, h64, c64} : {w32, i32, h32, c32};
    exp = {ew, eil, eh, ec};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s base%0d: got word=%h ill/hint/cust=%b expected word=%h ill/hint/cust=%b",
               tag, wide ? 64 : 32, act[34:3], act[2:0], exp[34:3], exp[2:0]);
    end
  endtask

  task automatic t_lwsp;
    logic [7:0] off;
    off = 8'd252;
    drive({3'b010, off[5], 5'd5, off[4:2], off[7:6], 2'b10});
    chk("R1 lwsp 252", 0, ei({4'b0, off}, 5'd2, 3'b010, 5'd5, 7'h03), 0, 0, 0);
    off = 8'd68;
    drive({3'b010, off[5], 5'd9, off[4:2], off[7:6], 2'b10});
    chk("R1 lwsp 68", 1, ei({4'b0, off}, 5'd2, 3'b010, 5'd9, 7'h03), 0, 0, 0);
    drive({3'b010, off[5], 5'd0, off[4:2], off[7:6], 2'b10});
    chk("R2 lwsp rd0", 0, 32'h0, 1, 0, 0);
  endtask

  task automatic t_ldsp;
    logic [8:0] off;
    off = 9'd504;
    drive({3'b011, off[5], 5'd10, off[4:3], off[8:6], 2'b10});
    chk("R3 ldsp 504", 1, ei({3'b0, off}, 5'd2, 3'b011, 5'd10, 7'h03), 0, 0, 0);
    chk("R3 ldsp narrow", 0, 32'h0, 1, 0, 0);
    off = 9'd72;
    drive({3'b011, off[5], 5'd0, off[4:3], off[8:6], 2'b10});
    chk("R3 ldsp rd0", 1, 32'h0, 1, 0, 0);
  endtask

  task automatic t_jumps;
    drive({3'b100, 1'b0, 5'd1, 5'd0, 2'b10});
    chk("R4 jr x1", 0, ei(12'h0, 5'd1, 3'b000, 5'd0, 7'h67), 0, 0, 0);
    drive({3'b100, 1'b0, 5'd0, 5'd0, 2'b10});
    chk("R4 jr x0", 0, 32'h0, 1, 0, 0);
    drive({3'b100, 1'b1, 5'd7, 5'd0, 2'b10});
    chk("R5 jalr x7", 1, ei(12'h0, 5'd7, 3'b000, 5'd1, 7'h67), 0, 0, 0);
    drive(16'h9002);
    chk("R5 ebreak", 0, 32'h0010_0073, 0, 0, 0);
  endtask

  task automatic t_regs;
    drive({3'b100, 1'b0, 5'd3, 5'd4, 2'b10});
    chk("R6 mv", 0, er(5'd4, 5'd0, 5'd3), 0, 0, 0);
    drive({3'b100, 1'b0, 5'd0, 5'd4, 2'b10});
    chk("R6 mv rd0 hint", 1, er(5'd4, 5'd0, 5'd0), 0, 1, 0);
    drive({3'b100, 1'b1, 5'd3, 5'd4, 2'b10});
    chk("R7 add", 0, er(5'd4, 5'd3, 5'd3), 0, 0, 0);
    drive({3'b100, 1'b1, 5'd0, 5'd31, 2'b10});
    chk("R7 add rd0 hint", 0, er(5'd31, 5'd0, 5'd0), 0, 1, 0);
  endtask

  task automatic t_shift;
    drive({3'b000, 1'b0, 5'd6, 5'd3, 2'b10});
    chk("R8 slli 3", 0, ei(12'd3, 5'd6, 3'b001, 5'd6, 7'h13), 0, 0, 0);
    drive({3'b000, 1'b0, 5'd6, 5'd0, 2'b10});
    chk("R8 slli sh0 hint", 1, ei(12'd0, 5'd6, 3'b001, 5'd6, 7'h13), 0, 1, 0);
    drive({3'b000, 1'b0, 5'd0, 5'd17, 2'b10});
    chk("R8 slli rd0 hint", 0, ei(12'd17, 5'd0, 3'b001, 5'd0, 7'h13), 0, 1, 0);
    drive({3'b000, 1'b1, 5'd6, 5'd1, 2'b10});
    chk("R9 slli 33 narrow", 0, 32'h0, 0, 0, 1);
    chk("R9 slli 33 wide", 1, ei(12'd33, 5'd6, 3'b001, 5'd6, 7'h13), 0, 0, 0);
    drive({3'b000, 1'b1, 5'd0, 5'd1, 2'b10});
    chk("R9 slli 33 rd0 narrow", 0, 32'h0, 0, 0, 1);
    chk("R9 slli 33 rd0 wide", 1, ei(12'd33, 5'd0, 3'b001, 5'd0, 7'h13), 0, 1, 0);
  endtask

  task automatic t_illegal;
    foreach (cin[i]) begin end
    for (int f = 0; f < 8; f++) begin
      if (f == 1 || f >= 5) begin
        drive({f[2:0], 1'b1, 5'd5, 5'd5, 2'b10});
        chk($sformatf("R10 funct3 %0d", f), f[0], 32'h0, 1, 0, 0);
      end
    end
    drive({3'b100, 1'b1, 5'd3, 5'd4, 2'b01});
    chk("R10 quadrant 01", 0, 32'h0, 1, 0, 0);
    drive({3'b010, 1'b1, 5'd5, 5'd5, 2'b11});
    chk("R10 quadrant 11", 1, 32'h0, 1, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cin = 16'h0000;
    #1;
    chk("R10 zero input", 0, 32'h0, 1, 0, 0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_lwsp();
    t_ldsp();
    t_jumps();
    t_regs();
    t_shift();
    t_illegal();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule